// File: doc/BRIEF.md
# Variable-Length Add Executor

This block executes the add family of a compact 32-bit-register instruction set whose instructions occupy one, two or three 16-bit parcels. A fetcher presents a 48-bit window with the first parcel in the top bits, and raises a valid strobe. The block works out the instruction length, pulls out the register numbers and any immediate, reads two operands from a 16 x 32 register file, adds them and writes the sum back on the same clock edge. The register-register forms also update four condition flags.

One cycle after the strobe the block pulses either a done signal, with the length in parcels so that the fetcher can advance, or an illegal signal when no add form matches. A read-only peek port returns any register's value so that the surrounding logic can observe the file.

The encoding is not self-delimiting, so the window is matched against all three forms at once and a fixed priority settles overlaps: the two-parcel form wins over the one-parcel form, and the one-parcel form wins over the three-parcel form.

Top module: `vla_add_exec`

## Requirements
- R1: While reset is asserted and after it is released, all 16 registers read 0, flags_o (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) is 0, and done_o and illegal_o are low.
- R2: A one-parcel word with window bits 47:44 = 4 and bits 43:40 = 0 or 1 writes dr (bits 39:36) with dr + sr (sr in bits 35:32), modulo 2^32, and reports length 1.
- R3: For the one-parcel form, N is bit 31 of the sum, Z is set when the sum is zero, C is the carry out of the unsigned 32-bit addition of the old dr and sr, and V is set when both operands have the same sign and the sum has a different sign. This also holds when dr equals sr.
- R4: A two-parcel word with window bits 47:44 = 4 and bits 27:24 = 2 writes dr (bits 23:20) with sr (bits 19:16) plus the 16-bit immediate in bits 43:28, sign-extended to 32 bits, and reports length 2.
- R5: A three-parcel word with window bits 15:12 = 4 and bits 11:8 = 3 writes dr (bits 7:4) with sr (bits 3:0) plus the 32-bit immediate in bits 47:16, and reports length 3.
- R6: The two immediate forms leave flags_o unchanged.
- R7: A valid window that matches no form pulses illegal_o for one cycle and keeps done_o low. It leaves every register and flags_o unchanged.
- R8: When a window matches more than one form, the two-parcel form takes priority, then the one-parcel form, then the three-parcel form.
- R9: The written register, flags_o, done_o and len_o all take their new values on the clock edge that samples the strobe. An instruction strobed in the very next cycle reads the updated register.
- R10: While insn_valid_i is low, the window is ignored: no register or flag changes, and done_o and illegal_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Window holds an instruction to execute |
| insn_win_i | input | 48 | Instruction window, first parcel in bits 47:32 |
| peek_sel_i | input | 4 | Register number for the peek port |
| peek_data_o | output | 32 | Current value of the selected register |
| done_o | output | 1 | One-cycle pulse: an add completed |
| len_o | output | 2 | Parcels consumed by the completed add (1 to 3) |
| illegal_o | output | 1 | One-cycle pulse: the window matched no add form |
| flags_o | output | 4 | Condition flags {N, Z, C, V} |

## Verification
Two functions can fall in the same cycle. The write-back of one instruction can coincide with an operand read by the next instruction strobed straight after it. Separately, a one-parcel add whose destination and source are the same register reads and overwrites that register in one cycle. The bench provokes the first case by strobing a dependent add in the cycle after a load. It provokes the second by adding a register to itself at the sign boundary. In both cases it compares the peek port and the flags with sums and carries computed arithmetically from its own register model.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 16;
  localparam int RIDX   = $clog2(NREG);
  localparam int PARCEL = 16;
  localparam int WIN    = 3 * PARCEL;

  typedef enum logic [1:0] {
    LEN_NONE  = 2'd0,
    LEN_ONE   = 2'd1,
    LEN_TWO   = 2'd2,
    LEN_THREE = 2'd3
  } len_e;

  typedef struct packed {
    logic            ok;
    logic            set_flags;
    logic            use_imm;
    len_e            len;
    logic [RIDX-1:0] dr;
    logic [RIDX-1:0] sr;
    logic [XLEN-1:0] imm;
  } dec_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/vla_decode.sv
module vla_decode
  import vla_pkg::*;
(
  input  logic [WIN-1:0] win,
  output dec_t           dec
);
  localparam logic [3:0] MAJ_ADD  = 4'h4;
  localparam logic [3:0] MIN_IMM2 = 4'h2;
  localparam logic [3:0] MIN_IMM3 = 4'h3;

  logic hit16, hit32, hit48;

  always_comb begin
    hit32 = (win[47:44] == MAJ_ADD) && (win[27:24] == MIN_IMM2);
    hit16 = (win[47:44] == MAJ_ADD) && (win[43:41] == 3'b000);
    hit48 = (win[15:12] == MAJ_ADD) && (win[11:8] == MIN_IMM3);
  end

  always_comb begin
    dec = '0;
    if (hit32) begin
      dec.ok      = 1'b1;
      dec.use_imm = 1'b1;
      dec.len     = LEN_TWO;
      dec.dr      = win[23:20];
      dec.sr      = win[19:16];
      dec.imm     = {{(XLEN-16){win[43]}}, win[43:28]};
    end else if (hit16) begin
      dec.ok        = 1'b1;
      dec.set_flags = 1'b1;
      dec.len       = LEN_ONE;
      dec.dr        = win[39:36];
      dec.sr        = win[35:32];
    end else if (hit48) begin
      dec.ok      = 1'b1;
      dec.use_imm = 1'b1;
      dec.len     = LEN_THREE;
      dec.dr      = win[7:4];
      dec.sr      = win[3:0];
      dec.imm     = XLEN'(win[47:16]);
    end
  end
endmodule

// File: rtl/vla_regfile.sv
module vla_regfile #(
  parameter int W = 32,
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] ra_a,
  output logic [W-1:0]         rd_a,
  input  logic [$clog2(N)-1:0] ra_b,
  output logic [W-1:0]         rd_b,
  input  logic [$clog2(N)-1:0] ra_p,
  output logic [W-1:0]         rd_p
);
  localparam int AW = $clog2(N);

  logic [N-1:0][W-1:0] mem_q, mem_d;
  logic [N-1:0]        wen;

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign wen[g]   = we && (waddr == AW'(g));
    assign mem_d[g] = wen[g] ? wdata : mem_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  assign rd_a = mem_q[ra_a];
  assign rd_b = mem_q[ra_b];
  assign rd_p = mem_q[ra_p];

  // R9: a written value is visible on the peek port one cycle later
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (ra_p == waddr)) |=> (rd_p == $past(wdata)));
endmodule

// File: rtl/vla_adder.sv
module vla_adder
  import vla_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output flags_t       fl
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[W-1:0];
    fl.c = wide[W];
    fl.n = wide[W-1];
    fl.z = (wide[W-1:0] == '0);
    fl.v = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/vla_add_exec.sv
module vla_add_exec
  import vla_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid_i,
  input  logic [47:0] insn_win_i,
  input  logic [3:0]  peek_sel_i,
  output logic [31:0] peek_data_o,
  output logic        done_o,
  output logic [1:0]  len_o,
  output logic        illegal_o,
  output logic [3:0]  flags_o
);
  dec_t            dec;
  logic [XLEN-1:0] dr_val, sr_val, add_b, sum;
  flags_t          add_fl;
  logic            go, bad;

  flags_t flags_q, flags_d;
  logic   flags_en;
  logic   done_q, done_d;
  len_e   len_q, len_d;
  logic   ill_q, ill_d;

  vla_decode u_dec (
    .win (insn_win_i),
    .dec (dec)
  );

  vla_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (go),
    .waddr (dec.dr),
    .wdata (sum),
    .ra_a  (dec.dr),
    .rd_a  (dr_val),
    .ra_b  (dec.sr),
    .rd_b  (sr_val),
    .ra_p  (peek_sel_i),
    .rd_p  (peek_data_o)
  );

  assign add_b = dec.use_imm ? dec.imm : dr_val;

  vla_adder #(.W(XLEN)) u_add (
    .a   (sr_val),
    .b   (add_b),
    .sum (sum),
    .fl  (add_fl)
  );

  always_comb begin
    go       = insn_valid_i && dec.ok;
    bad      = insn_valid_i && !dec.ok;
    flags_en = go && dec.set_flags;
    flags_d  = add_fl;
    done_d   = go;
    len_d    = go ? dec.len : LEN_NONE;
    ill_d    = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      done_q  <= 1'b0;
      len_q   <= LEN_NONE;
      ill_q   <= 1'b0;
    end else begin
      if (flags_en) flags_q <= flags_d;
      done_q <= done_d;
      len_q  <= len_d;
      ill_q  <= ill_d;
    end
  end

  assign done_o    = done_q;
  assign len_o     = len_q;
  assign illegal_o = ill_q;
  assign flags_o   = flags_q;

  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> done_o);
  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (illegal_o && !done_o && $stable(flags_o)));
  a_r6_imm_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dec.use_imm) |=> $stable(flags_o));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid_i |=> (!done_o && !illegal_o && $stable(flags_o)));
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_o != 2'd0));
endmodule

// File: tb/vla_add_exec_bench.sv
module vla_add_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic [47:0] win;
  logic [3:0]  peek;
  logic [31:0] peek_data;
  logic        done, ill;
  logic [1:0]  len;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [16];
  logic [3:0]  fm;

  always #4 clk = ~clk;

  vla_add_exec u_vla_add_exec (
    .clk (clk), .rst_n (rst_n), .insn_valid_i (vld), .insn_win_i (win),
    .peek_sel_i (peek), .peek_data_o (peek_data), .done_o (done),
    .len_o (len), .illegal_o (ill), .flags_o (flags)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input int idx, input logic [31:0] exp);
    peek = 4'(idx);
    #1;
    chk(req, {32'h0, peek_data}, {32'h0, exp});
  endtask

  function automatic logic [47:0] mk16(input logic [3:0] mn, input logic [3:0] d, input logic [3:0] s);
    return {4'h4, mn, d, s, 32'h0};
  endfunction
  function automatic logic [47:0] mk32(input logic [15:0] k, input logic [3:0] d, input logic [3:0] s);
    return {4'h4, k, 4'h2, d, s, 16'h0};
  endfunction
  function automatic logic [47:0] mk48(input logic [31:0] k, input logic [3:0] d, input logic [3:0] s);
    return {k, 4'h4, 4'h3, d, s};
  endfunction

  function automatic logic [3:0] add_flags(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return {s[31], s[31:0] == 32'h0, s[32], (a[31] == b[31]) && (s[31] != a[31])};
  endfunction

  task automatic issue(input logic [47:0] w);
    @(negedge clk);
    win = w;
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic load48(input string req, input logic [31:0] k, input int d, input int s);
    logic [31:0] e;
    e = model[s] + k;
    issue(mk48(k, 4'(d), 4'(s)));
    model[d] = e;
    chk({req, " len"}, {62'h0, len}, 64'd3);
    chk({req, " flags"}, {60'h0, flags}, {60'h0, fm});
    chk_reg({req, " reg"}, d, e);
  endtask

  task automatic rr(input string req, input logic [3:0] mn, input int d, input int s);
    logic [31:0] e;
    logic [3:0]  ef;
    e  = model[d] + model[s];
    ef = add_flags(model[d], model[s]);
    issue(mk16(mn, 4'(d), 4'(s)));
    model[d] = e;
    fm = ef;
    chk({req, " done"}, {63'h0, done}, 64'd1);
    chk({req, " len"}, {62'h0, len}, 64'd1);
    chk({req, " flags"}, {60'h0, flags}, {60'h0, ef});
    chk_reg({req, " reg"}, d, e);
  endtask

  initial begin
    logic [31:0] vals [8];
    logic [31:0] e;
    vals = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
             32'hffffffff, 32'h12345678, 32'h80000001, 32'hfffffffe};
    for (int i = 0; i < 16; i++) model[i] = 32'h0;
    fm = 4'h0;
    rst_n = 1'b0; vld = 1'b0; win = '0; peek = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flags in reset", {60'h0, flags}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", {60'h0, flags}, 64'h0);
    chk("R1 done", {63'h0, done}, 64'h0);
    chk("R1 illegal", {63'h0, ill}, 64'h0);
    for (int i = 0; i < 16; i++) chk_reg("R1 reg", i, 32'h0);

    // R5: three-parcel loads from r0
    for (int i = 1; i < 16; i++)
      load48("R5", {4'h8, 28'(i * 32'h0123457)}, i, 0);

    // R4 and R6: two-parcel sign-extended immediates
    e = model[1] + 32'hfffffff0;
    issue(mk32(16'hfff0, 4'd4, 4'd1));
    model[4] = e;
    chk("R4 len", {62'h0, len}, 64'd2);
    chk_reg("R4 negative imm", 4, e);
    chk("R6 flags", {60'h0, flags}, {60'h0, fm});
    e = model[2] + 32'h00007fff;
    issue(mk32(16'h7fff, 4'd5, 4'd2));
    model[5] = e;
    chk_reg("R4 positive imm", 5, e);

    // R2 and R3: register-register sweep over boundary operands
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        load48("R5 setup", vals[ia], 1, 0);
        load48("R5 setup", vals[ib], 2, 0);
        rr("R2/R3 sweep", 4'((ia + ib) & 1), 1, 2);
        chk_reg("R2 src kept", 2, vals[ib]);
        load48("R6 after rr", 32'h1, 3, 0);
      end
    end

    // R3: dr equals sr at the sign boundary
    load48("R5 setup", 32'h80000000, 3, 0);
    rr("R3 alias", 4'h0, 3, 3);
    chk("R3 alias flags", {60'h0, flags}, 64'b0111);

    // R8: two-parcel beats one-parcel; one-parcel beats three-parcel
    e = model[6] + 32'h00000123;
    issue(mk32(16'h0123, 4'd5, 4'd6));
    model[5] = e;
    chk("R8 len two", {62'h0, len}, 64'd2);
    chk_reg("R8 two-parcel reg", 5, e);
    e = model[7] + model[8];
    fm = add_flags(model[7], model[8]);
    issue(mk16(4'h1, 4'd7, 4'd8) | 48'h4300);
    model[7] = e;
    chk("R8 len one", {62'h0, len}, 64'd1);
    chk_reg("R8 one-parcel reg", 7, e);
    chk("R8 flags", {60'h0, flags}, {60'h0, fm});

    // R7: unmatched windows
    issue(48'h4500_0000_0000);
    chk("R7 illegal", {63'h0, ill}, 64'd1);
    chk("R7 done", {63'h0, done}, 64'd0);
    chk("R7 flags", {60'h0, flags}, {60'h0, fm});
    chk_reg("R7 r0 kept", 0, model[0]);
    issue(48'h0);
    chk("R7 illegal zero word", {63'h0, ill}, 64'd1);
    @(negedge clk);
    chk("R7 pulse ends", {63'h0, ill}, 64'd0);

    // R10: valid low with a legal word present
    win = mk16(4'h0, 4'd1, 4'd2);
    repeat (3) @(negedge clk);
    chk("R10 done", {63'h0, done}, 64'd0);
    chk("R10 flags", {60'h0, flags}, {60'h0, fm});
    chk_reg("R10 reg kept", 1, model[1]);

    // R9: dependent instruction strobed in the next cycle
    @(negedge clk);
    win = mk48(32'h5, 4'd9, 4'd0);
    vld = 1'b1;
    @(negedge clk);
    chk("R9 first done", {63'h0, done}, 64'd1);
    chk("R9 first len", {62'h0, len}, 64'd3);
    win = mk16(4'h0, 4'd9, 4'd9);
    @(negedge clk);
    vld = 1'b0;
    chk("R9 second len", {62'h0, len}, 64'd1);
    chk_reg("R9 forwarded sum", 9, 32'ha);
    chk("R9 flags", {60'h0, flags}, {60'h0, add_flags(32'h5, 32'h5)});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule